// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Arbiter

This block chooses, for every processor attached to an interrupt distributor, the single most urgent interrupt that is waiting for it, and decides whether that interrupt should raise the processor's request line. It does not own any interrupt state. Enable bits, per-CPU pending bits, priorities, priority masks and running priorities are all inputs, held by the register, acknowledge and end-of-interrupt logic around it. Each output is a pure function of one set of inputs, delivered a fixed number of cycles later.

A numerically lower priority value is more urgent. Sources below `PRIV_SRC` carry one private priority per CPU. Sources from `PRIV_SRC` upward share a single priority across all CPUs. The search runs as a pipelined binary tree of pairwise minimum stages, one register per tree level, so that a 64-source build has a short logic depth. The pipeline accepts a new input set every cycle.

Two thresholds are applied to the winner. The priority mask decides whether the winner is reported as the highest pending ID. A strict comparison against the CPU's running priority decides whether the request line goes high, so a preempting interrupt must be strictly more urgent than the one in service.

Top module: `irq_arb_top`

## Requirements
- R1: A source s is a candidate for CPU c only when `src_en_i[s]` is 1 and `pend_i[c*NUM_SRC + s]` is 1. A pending source that is not enabled, or that is pending only for another CPU, never appears on CPU c's outputs.
- R2: Among the candidates of a CPU, the one with the numerically smallest 8-bit priority wins.
- R3: When several candidates share the smallest priority, the lowest-numbered source wins.
- R4: For s < PRIV_SRC, CPU c uses the private priority `prio_priv_i[(c*PRIV_SRC + s)*8 +: 8]`. For s >= PRIV_SRC, every CPU uses the shared priority `prio_shr_i[(s-PRIV_SRC)*8 +: 8]`.
- R5: The winner's source number appears on `hp_id_o[c*10 +: 10]` only when its priority is less than or equal to `pmask_i[c*8 +: 8]`. Otherwise that field reads 1023.
- R6: `irq_o[c]` is 1 only when the winner is reported and its priority is strictly less than the 9-bit `run_prio_i[c*9 +: 9]`, where 256 means the CPU is idle. An equal running priority keeps the line low.
- R7: When `dist_en_i` is 0 or `cpu_en_i[c]` is 0, CPU c reports ID 1023 and holds `irq_o[c]` low.
- R8: While reset is asserted, and on the first cycle after it is released, every ID field reads 1023 and every request line is 0.
- R9: Outputs reflect the inputs sampled at a clock edge exactly LAT = $clog2(NUM_SRC)+2 edges later (8 for 64 sources), and a fresh input set may be applied every cycle.
- R10: A CPU with no candidate reports ID 1023 with its request line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dist_en_i | input | 1 | Distributor-wide enable |
| cpu_en_i | input | NUM_CPU | Per-CPU interface enable |
| src_en_i | input | NUM_SRC | Per-source enable |
| pend_i | input | NUM_CPU*NUM_SRC | Pending bits, CPU c at bits c*NUM_SRC +: NUM_SRC |
| prio_priv_i | input | NUM_CPU*PRIV_SRC*8 | Private priorities of the low sources, per CPU |
| prio_shr_i | input | (NUM_SRC-PRIV_SRC)*8 | Shared priorities of the upper sources |
| pmask_i | input | NUM_CPU*8 | Per-CPU priority mask |
| run_prio_i | input | NUM_CPU*9 | Per-CPU running priority, 256 = idle |
| hp_id_o | output | NUM_CPU*10 | Per-CPU highest pending ID, 1023 = none |
| irq_o | output | NUM_CPU | Per-CPU interrupt request |

## Verification
A corrupted tree node or candidate register appears as a wrong ID or a missing request on the affected CPU, exactly LAT cycles after the input set that exposes it. It clears itself once the pipeline has flushed, so a stale node cannot hide for longer than one pass. Misaligned control delay shows up as a mask, enable or running-priority change taking effect one or more cycles away from the ID it should gate. A cycle-by-cycle comparison against a linear-scan model over a random stream catches this within LAT cycles. A broken tie rule or a swapped private and shared priority lookup shows up only with equal or CPU-specific priorities, so directed cases set those up on purpose.

// File: rtl/irq_arb_pkg.sv
// Shared types and constants for the per-CPU pending interrupt arbiter.
// Assumes 8-bit priorities, a 9-bit running priority (256 = idle) and
// 10-bit interrupt IDs with 1023 reserved for "nothing".
package irq_arb_pkg;
    localparam int PRIO_W = 8;
    localparam int RUN_W  = 9;
    localparam int ID_W   = 10;
    localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;

    typedef struct packed {
        logic              on;
        logic [PRIO_W-1:0] mask;
        logic [RUN_W-1:0]  run;
    } cpu_ctl_t;

    // Pairwise selection: the upper-index entry wins only when it is valid
    // and strictly more urgent, so ties keep the lower-index entry.
    function automatic cand_t pick_urgent(cand_t lo, cand_t hi);
        if (hi.vld && (!lo.vld || (hi.prio < lo.prio)))
            return hi;
        return lo;
    endfunction
endpackage

// File: rtl/irq_cand_gather.sv
// Candidate stage for one CPU: qualifies each source with enable and
// pending, attaches the priority that applies to this CPU, and registers
// the result. Pads the leaf set up to a power of two with invalid entries.
// Assumes PRIV_SRC < NUM_SRC.
module irq_cand_gather
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int PRIV_SRC = 32,
    parameter int PAD      = 64
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_SRC-1:0]                  src_en_i,
    input  logic [NUM_SRC-1:0]                  pend_i,
    input  logic [PRIV_SRC*PRIO_W-1:0]          prio_priv_i,
    input  logic [(NUM_SRC-PRIV_SRC)*PRIO_W-1:0] prio_shr_i,
    output cand_t                               cand_o [PAD]
);
    for (genvar s = 0; s < PAD; s++) begin : g_src
        if (s < PRIV_SRC) begin : g_priv
            // Register a private-priority source candidate.
            always_ff @(posedge clk) begin
                if (!rst_n) cand_o[s] <= '0;
                else        cand_o[s] <= '{vld:  src_en_i[s] & pend_i[s],
                                           prio: prio_priv_i[s*PRIO_W +: PRIO_W],
                                           id:   ID_W'(s)};
            end
        end else if (s < NUM_SRC) begin : g_shr
            // Register a shared-priority source candidate.
            always_ff @(posedge clk) begin
                if (!rst_n) cand_o[s] <= '0;
                else        cand_o[s] <= '{vld:  src_en_i[s] & pend_i[s],
                                           prio: prio_shr_i[(s-PRIV_SRC)*PRIO_W +: PRIO_W],
                                           id:   ID_W'(s)};
            end
        end else begin : g_pad
            // Padding leaf that can never win.
            assign cand_o[s] = '0;
        end
    end
endmodule

// File: rtl/irq_min_tree.sv
// Pipelined minimum-priority reduction over 2**LVLS leaves. Nodes are held
// in heap order (node i combines children 2i and 2i+1), one register per
// tree level, so the latency is LVLS cycles. Lower leaf index wins ties.
// Assumes LVLS >= 1.
module irq_min_tree
    import irq_arb_pkg::*;
#(
    parameter int LVLS = 6,
    localparam int PAD = 1 << LVLS
) (
    input  logic  clk,
    input  logic  rst_n,
    input  cand_t leaf_i [PAD],
    output cand_t win_o
);
    cand_t node_q [1:PAD-1];
    cand_t tree_w [1:2*PAD-1];

    for (genvar j = 0; j < PAD; j++) begin : g_leaf
        assign tree_w[PAD+j] = leaf_i[j];
    end

    for (genvar i = 1; i < PAD; i++) begin : g_node
        assign tree_w[i] = node_q[i];
        // Keep the more urgent of the two children for the next level.
        always_ff @(posedge clk) begin
            if (!rst_n) node_q[i] <= '0;
            else        node_q[i] <= pick_urgent(tree_w[2*i], tree_w[2*i+1]);
        end
    end

    assign win_o = tree_w[1];
endmodule

// File: rtl/irq_cpu_gate.sv
// Final stage for one CPU: applies the interface enable, the priority mask
// (inclusive) and the running priority (strict) to the tree winner, and
// registers the reported ID and the request line.
module irq_cpu_gate
    import irq_arb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  cand_t           win_i,
    input  cpu_ctl_t        ctl_i,
    output logic [ID_W-1:0] hp_id_o,
    output logic            irq_o
);
    logic report_w;
    logic fire_w;

    // Decide visibility through the mask and preemption against running.
    always_comb begin
        report_w = ctl_i.on && win_i.vld && (win_i.prio <= ctl_i.mask);
        fire_w   = report_w && ({1'b0, win_i.prio} < ctl_i.run);
    end

    // Register the per-CPU outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_id_o <= NO_IRQ;
            irq_o   <= 1'b0;
        end else begin
            hp_id_o <= report_w ? win_i.id : NO_IRQ;
            irq_o   <= fire_w;
        end
    end
endmodule

// File: rtl/irq_arb_top.sv
// Per-CPU pending interrupt arbiter. For each CPU: a registered candidate
// stage, a pipelined min tree, and a registered threshold gate. The
// per-CPU control (enables, mask, running priority) is delayed to meet the
// tree output, so every output depends on one input set, LAT cycles old.
// Assumes 2 <= NUM_SRC <= 1023 and PRIV_SRC < NUM_SRC.
module irq_arb_top
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CPU  = 2,
    parameter int PRIV_SRC = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  dist_en_i,
    input  logic [NUM_CPU-1:0]                    cpu_en_i,
    input  logic [NUM_SRC-1:0]                    src_en_i,
    input  logic [NUM_CPU*NUM_SRC-1:0]            pend_i,
    input  logic [NUM_CPU*PRIV_SRC*8-1:0]         prio_priv_i,
    input  logic [(NUM_SRC-PRIV_SRC)*8-1:0]       prio_shr_i,
    input  logic [NUM_CPU*8-1:0]                  pmask_i,
    input  logic [NUM_CPU*9-1:0]                  run_prio_i,
    output logic [NUM_CPU*10-1:0]                 hp_id_o,
    output logic [NUM_CPU-1:0]                    irq_o
);
    localparam int LVLS    = $clog2(NUM_SRC);
    localparam int PAD     = 1 << LVLS;
    localparam int CTL_DLY = LVLS + 1;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        cand_t    leaf_w [PAD];
        cand_t    win_w;
        cpu_ctl_t ctl_q  [CTL_DLY];

        irq_cand_gather #(
            .NUM_SRC  (NUM_SRC),
            .PRIV_SRC (PRIV_SRC),
            .PAD      (PAD)
        ) gather_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_en_i    (src_en_i),
            .pend_i      (pend_i[c*NUM_SRC +: NUM_SRC]),
            .prio_priv_i (prio_priv_i[c*PRIV_SRC*PRIO_W +: PRIV_SRC*PRIO_W]),
            .prio_shr_i  (prio_shr_i),
            .cand_o      (leaf_w)
        );

        irq_min_tree #(
            .LVLS (LVLS)
        ) tree_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .leaf_i (leaf_w),
            .win_o  (win_w)
        );

        // Capture this CPU's control word alongside the candidate stage.
        always_ff @(posedge clk) begin
            if (!rst_n) ctl_q[0] <= '0;
            else        ctl_q[0] <= '{on:   dist_en_i & cpu_en_i[c],
                                      mask: pmask_i[c*PRIO_W +: PRIO_W],
                                      run:  run_prio_i[c*RUN_W +: RUN_W]};
        end

        for (genvar k = 1; k < CTL_DLY; k++) begin : g_dly
            // Shift the control word in step with one tree level.
            always_ff @(posedge clk) begin
                if (!rst_n) ctl_q[k] <= '0;
                else        ctl_q[k] <= ctl_q[k-1];
            end
        end

        irq_cpu_gate gate_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .win_i   (win_w),
            .ctl_i   (ctl_q[CTL_DLY-1]),
            .hp_id_o (hp_id_o[c*ID_W +: ID_W]),
            .irq_o   (irq_o[c])
        );
    end
endmodule

// File: rtl/irq_arb_chk.sv
// Property checker for irq_arb_top, attached by bind. Watches only the
// top-level ports; a saturating counter measures how long a CPU has been
// disabled so the pipeline latency is checked without deep history.
module irq_arb_chk
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   dist_en_i,
    input logic [NUM_CPU-1:0]     cpu_en_i,
    input logic [NUM_CPU*10-1:0]  hp_id_o,
    input logic [NUM_CPU-1:0]     irq_o
);
    localparam int LAT = $clog2(NUM_SRC) + 2;
    localparam int CW  = $clog2(LAT + 1) + 1;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        logic [CW-1:0] off_cnt;
        logic          idle_w;

        assign idle_w = (hp_id_o[c*ID_W +: ID_W] == NO_IRQ) && !irq_o[c];

        // Count consecutive cycles in which this CPU is disabled.
        always_ff @(posedge clk) begin
            if (!rst_n)                        off_cnt <= '0;
            else if (dist_en_i && cpu_en_i[c]) off_cnt <= '0;
            else if (off_cnt < CW'(LAT))       off_cnt <= off_cnt + 1'b1;
        end

        a_r6_req_needs_id: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> (hp_id_o[c*ID_W +: ID_W] != NO_IRQ));

        a_r1_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            (hp_id_o[c*ID_W +: ID_W] != NO_IRQ) |-> (hp_id_o[c*ID_W +: ID_W] < ID_W'(NUM_SRC)));

        a_r7_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (off_cnt >= CW'(LAT)) |-> idle_w);

        a_r8_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> idle_w);
    end
endmodule

bind irq_arb_top irq_arb_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dist_en_i (dist_en_i),
    .cpu_en_i  (cpu_en_i),
    .hp_id_o   (hp_id_o),
    .irq_o     (irq_o)
);

// File: tb/irq_arb_top_tb_top.sv
// Directed bench for irq_arb_top: one task per scenario, plus a random
// stream compared cycle by cycle against a linear-scan reference model.
module irq_arb_top_tb_top;
    localparam int NS  = 64;
    localparam int NC  = 2;
    localparam int NP  = 32;
    localparam int LAT = $clog2(NS) + 2;
    localparam int NSTREAM = 400;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 dist_en;
    logic [NC-1:0]        cpu_en;
    logic [NS-1:0]        src_en;
    logic [NC*NS-1:0]     pend;
    logic [NC*NP*8-1:0]   prio_priv;
    logic [(NS-NP)*8-1:0] prio_shr;
    logic [NC*8-1:0]      pmask;
    logic [NC*9-1:0]      run_prio;
    logic [NC*10-1:0]     hp_id;
    logic [NC-1:0]        irq;

    int checks = 0;
    int errors = 0;
    logic [9:0] exp_id [NC][NSTREAM];
    logic       exp_rq [NC][NSTREAM];

    always #2 clk = ~clk;

    irq_arb_top #(.NUM_SRC(NS), .NUM_CPU(NC), .PRIV_SRC(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .dist_en_i(dist_en), .cpu_en_i(cpu_en),
        .src_en_i(src_en), .pend_i(pend), .prio_priv_i(prio_priv),
        .prio_shr_i(prio_shr), .pmask_i(pmask), .run_prio_i(run_prio),
        .hp_id_o(hp_id), .irq_o(irq)
    );

    function automatic logic [7:0] prio_of(int s, int c);
        if (s < NP) return prio_priv[(c*NP + s)*8 +: 8];
        return prio_shr[(s-NP)*8 +: 8];
    endfunction

    // Linear-scan reference built from the requirements.
    task automatic ref_calc(input int c, output logic [9:0] id, output logic rq);
        int best = 256;
        int bid = 1023;
        for (int s = 0; s < NS; s++) begin
            if (src_en[s] && pend[c*NS + s] && (int'(prio_of(s, c)) < best)) begin
                best = int'(prio_of(s, c));
                bid = s;
            end
        end
        id = 10'd1023;
        rq = 1'b0;
        if (dist_en && cpu_en[c] && best <= int'(pmask[c*8 +: 8])) begin
            id = 10'(bid);
            rq = best < int'(run_prio[c*9 +: 9]);
        end
    endtask

    task automatic set_prio(input int s, input int c, input logic [7:0] v);
        if (s < NP) prio_priv[(c*NP + s)*8 +: 8] = v;
        else        prio_shr[(s-NP)*8 +: 8] = v;
    endtask

    task automatic pend_on(input int s, input int c);
        src_en[s] = 1'b1;
        pend[c*NS + s] = 1'b1;
    endtask

    task automatic clean();
        dist_en = 1'b1;
        cpu_en = '1;
        src_en = '0;
        pend = '0;
        prio_priv = '0;
        prio_shr = '0;
        pmask = {NC{8'hFF}};
        run_prio = {NC{9'd256}};
    endtask

    task automatic settle();
        repeat (LAT + 2) @(negedge clk);
    endtask

    task automatic check(input string req, input int c, input logic [9:0] eid, input logic erq);
        checks++;
        if (hp_id[c*10 +: 10] !== eid || irq[c] !== erq) begin
            errors++;
            $display("FAIL %s cpu%0d: id=%0d irq=%0b expected id=%0d irq=%0b",
                     req, c, hp_id[c*10 +: 10], irq[c], eid, erq);
        end
    endtask

    task automatic t_reset();
        clean();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", 0, 10'd1023, 1'b0);
        check("R8", 1, 10'd1023, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", 0, 10'd1023, 1'b0);
    endtask

    task automatic t_candidate();
        clean();
        set_prio(40, 0, 8'h50);
        set_prio(50, 0, 8'h30);
        pend_on(40, 0);
        pend_on(50, 1);
        pend[0*NS + 20] = 1'b1;
        set_prio(20, 0, 8'h01);
        settle();
        check("R1", 0, 10'd40, 1'b1);
        check("R1", 1, 10'd50, 1'b1);
        pend_on(50, 0);
        settle();
        check("R2", 0, 10'd50, 1'b1);
    endtask

    task automatic t_tie();
        clean();
        set_prio(60, 0, 8'h20);
        set_prio(33, 0, 8'h20);
        set_prio(3, 0, 8'h20);
        pend_on(60, 0);
        pend_on(33, 0);
        settle();
        check("R3", 0, 10'd33, 1'b1);
        pend_on(3, 0);
        settle();
        check("R3", 0, 10'd3, 1'b1);
    endtask

    task automatic t_private();
        clean();
        set_prio(5, 0, 8'h10);
        set_prio(5, 1, 8'h90);
        set_prio(40, 0, 8'h40);
        pend_on(5, 0); pend_on(5, 1);
        pend_on(40, 0); pend_on(40, 1);
        settle();
        check("R4", 0, 10'd5, 1'b1);
        check("R4", 1, 10'd40, 1'b1);
    endtask

    task automatic t_mask();
        clean();
        set_prio(45, 0, 8'h80);
        pend_on(45, 0);
        pmask[7:0] = 8'h80;
        settle();
        check("R5", 0, 10'd45, 1'b1);
        pmask[7:0] = 8'h7F;
        settle();
        check("R5", 0, 10'd1023, 1'b0);
    endtask

    task automatic t_running();
        clean();
        set_prio(35, 1, 8'h40);
        pend_on(35, 1);
        run_prio[9 +: 9] = 9'h040;
        settle();
        check("R6", 1, 10'd35, 1'b0);
        run_prio[9 +: 9] = 9'h041;
        settle();
        check("R6", 1, 10'd35, 1'b1);
        run_prio[9 +: 9] = 9'h000;
        settle();
        check("R6", 1, 10'd35, 1'b0);
    endtask

    task automatic t_disable();
        clean();
        pend_on(36, 0); pend_on(36, 1);
        dist_en = 1'b0;
        settle();
        check("R7", 0, 10'd1023, 1'b0);
        check("R7", 1, 10'd1023, 1'b0);
        dist_en = 1'b1;
        cpu_en = 2'b01;
        settle();
        check("R7", 0, 10'd36, 1'b1);
        check("R7", 1, 10'd1023, 1'b0);
    endtask

    task automatic t_empty();
        clean();
        pend[0*NS + 10] = 1'b1;
        src_en[11] = 1'b1;
        settle();
        check("R10", 0, 10'd1023, 1'b0);
        check("R10", 1, 10'd1023, 1'b0);
    endtask

    task automatic t_latency();
        clean();
        settle();
        pend_on(63, 0);
        repeat (LAT - 1) @(negedge clk);
        check("R9", 0, 10'd1023, 1'b0);
        @(negedge clk);
        check("R9", 0, 10'd63, 1'b1);
    endtask

    task automatic t_stream();
        clean();
        for (int k = 0; k < NSTREAM; k++) begin
            @(negedge clk);
            if (k >= LAT) begin
                for (int c = 0; c < NC; c++) check("R9", c, exp_id[c][k-LAT], exp_rq[c][k-LAT]);
            end
            dist_en = ($urandom % 16) != 0;
            cpu_en = NC'($urandom | ((($urandom % 4) != 0) ? 32'h3 : 32'h0));
            src_en = {$urandom, $urandom};
            pend = {$urandom & $urandom, $urandom & $urandom, $urandom & $urandom, $urandom & $urandom};
            for (int c = 0; c < NC; c++) begin
                pmask[c*8 +: 8] = (($urandom % 3) == 0) ? 8'($urandom) : 8'hFF;
                run_prio[c*9 +: 9] = (($urandom % 3) == 0) ? 9'd256 : 9'($urandom % 257);
                for (int s = 0; s < NP; s++) set_prio(s, c, 8'(($urandom % 8) * 32 + ($urandom % 2)));
            end
            for (int s = NP; s < NS; s++) set_prio(s, 0, 8'(($urandom % 8) * 32 + ($urandom % 2)));
            for (int c = 0; c < NC; c++) ref_calc(c, exp_id[c][k], exp_rq[c][k]);
        end
    endtask

    // Watchdog: an overrun counts as a failed check.
    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Scenario sequence.
    initial begin
        t_reset();
        t_candidate();
        t_tie();
        t_private();
        t_mask();
        t_running();
        t_disable();
        t_empty();
        t_latency();
        t_stream();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule